// File: doc/BRIEF.md
# Synchronized DMA Request Pulse Generator

This block drives the DMA request line of a parallel port whose double-buffered data latches should be kept full while sending and empty while receiving. Two events can call for a transfer: a bus access that selects the port (an active-low chip select) and a strobe from the peripheral handshake. Each trigger passes through its own synchronizer. The chip select is sampled on falling clock edges and the handshake strobe on rising edges. The request is issued only if the port configuration enables DMA requests and the surrounding port logic reports that its transfer condition holds.

Once a trigger is accepted, the block waits a fixed time and then drives a request pulse of fixed width. The chip-select path waits three clocks and the handshake path two and a half clocks, counted from the edge at which the trigger becomes synchronized. Because of the half clock, the request rises and falls on falling clock edges, so the timing section is clocked on the falling edge while the handshake synchronizer runs on the rising edge. Only one request is in progress at any time.

Top module: `dreq_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `dreq` is low. Reset abandons any pending or active request, so no pulse appears after reset unless a new trigger arrives.
- R2: A chip-select assertion (`cs_n` going from 1 to 0) becomes synchronized on the falling edge at which the last of `SYNC_STAGES` falling-edge samples sees it. If the request is accepted, `dreq` rises on the falling edge `CS_DELAY_CLKS` (3) clocks after that edge.
- R3: A handshake assertion (`hs_strobe` going from 0 to 1) becomes synchronized on the rising edge at which the last of `SYNC_STAGES` rising-edge samples sees it. If the request is accepted, `dreq` rises 2.5 clocks after that edge, on the falling edge `HS_DELAY_CLKS` (2) clocks after the first falling edge that follows it.
- R4: Every request pulse stays high for exactly `PULSE_CLKS` (3) clocks and rises and falls on falling clock edges.
- R5: A trigger is accepted only if `dreq_en` and `xfer_ready` are both 1 on the falling edge at which it is taken. Otherwise it produces no pulse.
- R6: A trigger whose acceptance edge falls while a request is pending or while `dreq` is high, including the edge on which `dreq` falls, is ignored. A trigger is accepted again from the following falling edge.
- R7: A trigger that stays asserted produces at most one request. A further request needs the trigger to be deasserted and then asserted again.
- R8: If both triggers reach their acceptance edge on the same falling edge, the chip-select path wins and uses its delay. The handshake trigger is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low bus chip select, asynchronous to `clk` |
| hs_strobe | input | 1 | Active-high peripheral handshake strobe, asynchronous to `clk` |
| dreq_en | input | 1 | DMA request enable from the port configuration |
| xfer_ready | input | 1 | Port logic reports that a transfer condition is met |
| dreq | output | 1 | DMA request pulse, active high |

## Verification
The hardest case to reach is two triggers from different clock edges landing on the same falling edge. The chip-select and handshake paths have different synchronizer phases, so simultaneous arrival needs the handshake strobe to lead the chip select by exactly one clock. The directed stimulus builds that offset on purpose, and other directed sequences launch a handshake inside a pending chip-select request and retrigger next to the falling edge of a pulse. The random phase toggles both triggers with independent hold times and flips the enables, which reaches many more collisions. Every half cycle is then compared with a window model that works in nanoseconds.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_PULSE = 2'd2
  } dreq_phase_e;

  // Counter width for a terminal count value
  function automatic int unsigned count_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // Counters run down to zero, so a span of N clocks loads N-1
  function automatic int unsigned span_to_load(input int unsigned span);
    return (span == 0) ? 0 : span - 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dreq_sync_edge.sv
module dreq_sync_edge #(
  parameter int unsigned STAGES     = 2,
  parameter bit          ACTIVE_LOW = 1'b0,
  parameter bit          FALL_EDGE  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic sync_lvl,
  output logic rise_next,
  output logic rise_seen
);

  logic             act_in;
  logic [STAGES-1:0] chain;
  logic             last_q;

  assign act_in = ACTIVE_LOW ? ~pin : pin;

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain  <= '0;
          last_q <= 1'b0;
        end else begin
          chain  <= {chain[STAGES-2:0], act_in};
          last_q <= chain[STAGES-1];
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain  <= '0;
          last_q <= 1'b0;
        end else begin
          chain  <= {chain[STAGES-2:0], act_in};
          last_q <= chain[STAGES-1];
        end
      end
    end
  endgenerate

  assign sync_lvl  = chain[STAGES-1];
  // asserting edge takes place at the coming edge of this domain
  assign rise_next = chain[STAGES-2] & ~chain[STAGES-1];
  // asserting edge took place at the most recent edge of this domain
  assign rise_seen = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/dreq_gate.sv
module dreq_gate #(
  parameter int unsigned CS_DELAY_CLKS = 3,
  parameter int unsigned HS_DELAY_CLKS = 2,
  parameter int unsigned CNT_W         = 2
) (
  input  logic             cs_fire,
  input  logic             hs_fire,
  input  logic             dreq_en,
  input  logic             xfer_ready,
  input  logic             timer_idle,
  output logic             accept,
  output logic             take_cs,
  output logic [CNT_W-1:0] load_val
);

  import dreq_pkg::*;

  localparam logic [CNT_W-1:0] CS_LOAD = CNT_W'(span_to_load(CS_DELAY_CLKS));
  localparam logic [CNT_W-1:0] HS_LOAD = CNT_W'(span_to_load(HS_DELAY_CLKS));

  logic allowed;
  logic any_fire;

  assign allowed  = dreq_en & xfer_ready & timer_idle;
  assign any_fire = cs_fire | hs_fire;
  assign accept   = allowed & any_fire;
  // bus-side trigger has priority on a shared edge
  assign take_cs  = cs_fire;
  assign load_val = take_cs ? CS_LOAD : HS_LOAD;

endmodule

// File: rtl/dreq_pulse_timer.sv
module dreq_pulse_timer #(
  parameter int unsigned PULSE_CLKS = 3,
  parameter int unsigned CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] load_val,
  output logic             timer_idle,
  output logic             dreq
);

  import dreq_pkg::*;

  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(span_to_load(PULSE_CLKS));

  dreq_phase_e      phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_done;

  assign cnt_done   = (cnt_q == '0);
  assign timer_idle = (phase_q == PH_IDLE);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dreq    <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_WAIT;
            cnt_q   <= load_val;
          end
        end
        PH_WAIT: begin
          if (cnt_done) begin
            phase_q <= PH_PULSE;
            cnt_q   <= PULSE_LOAD;
            dreq    <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_PULSE: begin
          if (cnt_done) begin
            phase_q <= PH_IDLE;
            dreq    <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
          dreq    <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dreq_pulse_gen.sv
module dreq_pulse_gen #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned CS_DELAY_CLKS = 3,
  parameter int unsigned HS_DELAY_CLKS = 2,
  parameter int unsigned PULSE_CLKS    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic hs_strobe,
  input  logic dreq_en,
  input  logic xfer_ready,
  output logic dreq
);

  import dreq_pkg::*;

  localparam int unsigned MAX_LOAD =
    max3(span_to_load(CS_DELAY_CLKS), span_to_load(HS_DELAY_CLKS), span_to_load(PULSE_CLKS));
  localparam int unsigned CNT_W = count_width(MAX_LOAD);

  logic             cs_lvl, cs_fire, cs_seen_unused;
  logic             hs_lvl, hs_next_unused, hs_fire;
  logic             accept, take_cs, timer_idle;
  logic [CNT_W-1:0] load_val;

  // chip select: active low, sampled on falling edges
  dreq_sync_edge #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b1), .FALL_EDGE(1'b1)) u_cs_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (cs_n),
    .sync_lvl  (cs_lvl),
    .rise_next (cs_fire),
    .rise_seen (cs_seen_unused)
  );

  // handshake: active high, sampled on rising edges
  dreq_sync_edge #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b0), .FALL_EDGE(1'b0)) u_hs_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (hs_strobe),
    .sync_lvl  (hs_lvl),
    .rise_next (hs_next_unused),
    .rise_seen (hs_fire)
  );

  dreq_gate #(.CS_DELAY_CLKS(CS_DELAY_CLKS), .HS_DELAY_CLKS(HS_DELAY_CLKS), .CNT_W(CNT_W)) u_gate (
    .cs_fire    (cs_fire),
    .hs_fire    (hs_fire),
    .dreq_en    (dreq_en),
    .xfer_ready (xfer_ready),
    .timer_idle (timer_idle),
    .accept     (accept),
    .take_cs    (take_cs),
    .load_val   (load_val)
  );

  dreq_pulse_timer #(.PULSE_CLKS(PULSE_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .load_val   (load_val),
    .timer_idle (timer_idle),
    .dreq       (dreq)
  );

endmodule

// File: rtl/dreq_pulse_chk.sv
module dreq_pulse_chk #(
  parameter int unsigned PULSE_CLKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic dreq_en,
  input logic xfer_ready,
  input logic dreq,
  input logic accept,
  input logic cs_fire
);

  localparam int unsigned HW = (PULSE_CLKS < 2) ? 2 : $clog2(PULSE_CLKS + 2);

  logic [HW-1:0] hi_cnt;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (dreq) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) reset_low_chk: assert (!dreq);
  end

  // R4
  pulse_width_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(dreq) |-> (hi_cnt == HW'(PULSE_CLKS)));

  // R5
  gated_accept_chk: assert property (@(negedge clk) disable iff (!rst_n)
    accept |-> (dreq_en && xfer_ready));

  // R6
  busy_ignore_chk: assert property (@(negedge clk) disable iff (!rst_n)
    accept |-> !dreq);

  // R6
  no_early_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    accept |=> !dreq);

  // R7
  single_fire_chk: assert property (@(negedge clk) disable iff (!rst_n)
    cs_fire |=> !cs_fire);

endmodule

bind dreq_pulse_gen dreq_pulse_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dreq_en    (dreq_en),
  .xfer_ready (xfer_ready),
  .dreq       (dreq),
  .accept     (accept),
  .cs_fire    (cs_fire)
);

// File: tb/tb_dreq_pulse_gen.sv
`timescale 1ns/1ps
module tb_dreq_pulse_gen;

  localparam int S   = 2;
  localparam int CSD = 3;
  localparam int HSD = 2;
  localparam int PW  = 3;
  localparam time T  = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, hs_strobe = 1'b0;
  logic dreq_en = 1'b0, xfer_ready = 1'b0;
  logic dreq;

  int  n_chk = 0, n_fail = 0, rises = 0;
  time cs_acc = 0, hs_acc = 0, w_rise = 0, w_fall = 0;
  time t_rise = 0, t_fall = 0, td = 0;
  string w_tag = "R2", ctx = "R1";

  dreq_pulse_gen #(.SYNC_STAGES(S), .CS_DELAY_CLKS(CSD), .HS_DELAY_CLKS(HSD),
                   .PULSE_CLKS(PW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hs_strobe(hs_strobe),
    .dreq_en(dreq_en), .xfer_ready(xfer_ready), .dreq(dreq));

  always #4 clk = ~clk;  // 125 MHz

  // accept instants in ns, from a drive made 2 ns after a rising edge
  function automatic time cs_accept_at(time drive_t);
    return drive_t + 2 + T * (S - 1);
  endfunction
  function automatic time hs_accept_at(time drive_t);
    return drive_t + 6 + T * (S - 1) + 4;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // window model, evaluated on falling edges
  always @(negedge clk) begin
    if (rst_n && dreq_en && xfer_ready && $time > w_fall) begin
      if (cs_acc == $time) begin
        w_rise = $time + CSD * T; w_fall = w_rise + PW * T; w_tag = "R2";
      end else if (hs_acc == $time) begin
        w_rise = $time + HSD * T; w_fall = w_rise + PW * T; w_tag = "R3";
      end
    end
  end

  always @(clk) begin
    #1;
    begin
      bit exp_v;
      exp_v = (w_fall != 0) && ($time - 1 >= w_rise) && ($time - 1 < w_fall);
      n_chk++;
      if (dreq !== exp_v) begin
        n_fail++;
        $display("FAIL %s at %0t: actual %b expected %b", exp_v ? w_tag : ctx,
                 $time, dreq, exp_v);
      end
    end
  end

  always @(posedge dreq) begin t_rise = $time; rises++; end
  always @(negedge dreq) t_fall = $time;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_cs(input bit act);
    if (act && cs_n) cs_acc = cs_accept_at($time);
    cs_n = !act;
  endtask

  task automatic set_hs(input bit act);
    if (act && !hs_strobe) hs_acc = hs_accept_at($time);
    hs_strobe = act;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; hs_strobe = 1'b0;
    cs_acc = 0; hs_acc = 0; w_rise = 0; w_fall = 0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  initial begin
    #(T * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd4242));
    ctx = "R1";
    step(4);
    check("R1", dreq, 0);
    do_reset();

    // R2 and R4: chip-select path timing and width
    dreq_en = 1; xfer_ready = 1; ctx = "R2";
    td = $time; set_cs(1); step(4); set_cs(0); step(12);
    check("R2", t_rise - td, 2 + T * (S - 1) + CSD * T);
    check("R4", t_fall - t_rise, PW * T);

    // R3 and R4: handshake path
    ctx = "R3";
    td = $time; set_hs(1); step(4); set_hs(0); step(12);
    check("R3", t_rise - td, 6 + T * (S - 1) + 4 + HSD * T);
    check("R4", t_fall - t_rise, PW * T);

    // R5: enable low, then condition low
    ctx = "R5"; r0 = rises;
    dreq_en = 0; set_cs(1); step(4); set_cs(0); step(10);
    dreq_en = 1; xfer_ready = 0; set_hs(1); step(4); set_hs(0); step(10);
    check("R5", rises - r0, 0);
    xfer_ready = 1;

    // R7: held trigger gives one pulse
    ctx = "R7"; r0 = rises;
    set_cs(1); set_hs(1); step(30); set_cs(0); set_hs(0); step(10);
    check("R7", rises - r0, 1);

    // R6: handshake while chip-select request pending
    ctx = "R6"; r0 = rises;
    td = $time; set_cs(1); step(2); set_hs(1); step(3); set_cs(0); step(3); set_hs(0);
    step(12);
    check("R6", rises - r0, 1);
    check("R6", t_rise - td, 2 + T * (S - 1) + CSD * T);

    // R8: handshake leads chip select by one clock, same accept edge
    ctx = "R8"; r0 = rises;
    td = $time; set_hs(1); step(1); set_cs(1); step(4); set_hs(0); set_cs(0); step(12);
    check("R8", rises - r0, 1);
    check("R8", t_rise - td, T + 2 + T * (S - 1) + CSD * T);

    // R1: reset in the middle of a pulse, no pulse after release
    ctx = "R1"; r0 = rises;
    set_cs(1); step(5);
    do_reset();
    set_cs(0); step(12);
    check("R1", rises - r0, 1);
    check("R1", dreq, 0);

    // random phase
    ctx = "R6";
    begin
      int cs_hold = 3, hs_hold = 5;
      for (int i = 0; i < 3000; i++) begin
        step(1);
        if ($urandom % 16 == 0) dreq_en = ($urandom % 4) != 0;
        if ($urandom % 16 == 0) xfer_ready = ($urandom % 4) != 0;
        if (--cs_hold == 0) begin set_cs(cs_n); cs_hold = 3 + $urandom % 8; end
        if (--hs_hold == 0) begin set_hs(!hs_strobe); hs_hold = 3 + $urandom % 8; end
      end
    end
    set_cs(0); set_hs(0); step(15);
    check("R4", t_fall - t_rise, PW * T);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule